// File: doc/BRIEF.md
# Counter-Sequenced Control Unit

This block is the control half of a small iterative datapath. Its whole state is one small loadable counter. On every clock edge the counter does one of three things: it counts up by one, it loads a constant, or it holds (holding only while reset is not asserted and neither action is chosen, which the five-state flow never needs). A decoder turns the counter value into one-hot state lines. Those lines drive the load and select strobes for the datapath, and they also drive a registered completion flag.

The sequence runs as follows. An idle state waits for a start request. A setup state loads the operands. Two working states prepare and update intermediate values. A test state then closes the loop: it either branches back to the prepare state or returns to idle, depending on a loop condition computed by the datapath. The datapath itself lies outside this block. The strobes are Moore outputs, so they depend only on the counter value, and the inputs affect only the next count.

Top module: `ctr_seq_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the unit in idle, with counter value 0 and all seven strobes low, and sets done to 1. This also applies while a sequence is in progress.
- R2: In idle with start low, the counter reloads 0, so the unit stays idle with all strobes low. Done is 1 from the second idle cycle on.
- R3: In idle with start high, the next cycle is the setup state (counter 1). In that state src_load, acc_load and tol_load are high and all other strobes are low.
- R4: Setup is followed by the prepare state (counter 2), where tmp_load and tmp_sel are high. Prepare is followed by the update state (counter 3), where est_load alone is high.
- R5: After update comes the test state (counter 4), where acc_load and acc_sel are high. If loop_cond is 1 in test, the counter loads 2 and the next cycle is the prepare state.
- R6: If loop_cond is 0 in test, the counter loads 0 and the next cycle is idle with all strobes low. Count-up and load are never chosen in the same cycle.
- R7: Done is cleared by the edge that leaves setup and stays 0 through prepare, update and test. It is still 0 in the first idle cycle after a return, and it becomes 1 at the edge that ends that cycle.
- R8: The start input is ignored in every state except idle. Holding start high keeps the sequence unchanged, and only an idle cycle with start high begins a new run.
- R9: The loop_cond input is ignored in every state except test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled only in idle |
| loop_cond | input | 1 | Loop condition from the datapath, sampled only in test |
| src_load | output | 1 | Operand load strobe (setup) |
| acc_load | output | 1 | Accumulator load strobe (setup and test) |
| tol_load | output | 1 | Tolerance load strobe (setup) |
| tmp_load | output | 1 | Intermediate load strobe (prepare) |
| est_load | output | 1 | Estimate load strobe (update) |
| tmp_sel | output | 1 | Intermediate input select (prepare) |
| acc_sel | output | 1 | Accumulator input select (test) |
| done | output | 1 | Registered completion flag |

## Verification
The properties assume that start and loop_cond are known, stable values at each rising edge. They also assume that rst is asserted at the first edge, so the counter starts from a defined value.

The bench changes every input only at falling edges, so each input is settled half a period before the edge that samples it. It holds reset for several edges before releasing it. The bench also toggles start and loop_cond in states where they must have no effect, so each property that claims an input is ignored gets inputs that could break it.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

  // Counter codes of the five legal states; the branch loads depend on them.
  localparam int ST_IDLE  = 0;
  localparam int ST_SETUP = 1;
  localparam int ST_PREP  = 2;
  localparam int ST_UPD   = 3;
  localparam int ST_TEST  = 4;
  localparam int ST_COUNT = 5;

  typedef struct packed {
    logic src_load;
    logic acc_load;
    logic tol_load;
    logic tmp_load;
    logic est_load;
    logic tmp_sel;
    logic acc_sel;
    logic done_set;
    logic done_clr;
  } strobe_t;

  // Moore output table as a function of the legal one-hot state lines.
  function automatic strobe_t strobes_of(input logic [ST_COUNT-1:0] st);
    strobe_t s;
    s          = '0;
    s.done_set = st[ST_IDLE];
    s.done_clr = st[ST_SETUP];
    s.src_load = st[ST_SETUP];
    s.tol_load = st[ST_SETUP];
    s.acc_load = st[ST_SETUP] | st[ST_TEST];
    s.tmp_load = st[ST_PREP];
    s.tmp_sel  = st[ST_PREP];
    s.est_load = st[ST_UPD];
    s.acc_sel  = st[ST_TEST];
    return s;
  endfunction

  // Next value of a set/clear flag; set wins if both are requested.
  function automatic logic flag_next(input logic cur, input logic set_r, input logic clr_r);
    return set_r | (cur & ~clr_r);
  endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         par_ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (par_ld) begin
      q <= ld_val;
    end else if (cnt_en) begin
      q <= q + W'(1);
    end
  end

endmodule

// File: rtl/seq_decoder.sv
module seq_decoder #(
  parameter int W     = 3,
  parameter int LINES = 1 << W
) (
  input  logic [W-1:0]     q,
  output logic [LINES-1:0] oh
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign oh[i] = (q == W'(i));
  end

endmodule

// File: rtl/seq_branch.sv
module seq_branch
  import seq_ctrl_pkg::*;
#(
  parameter int W     = 3,
  parameter int LINES = 1 << W
) (
  input  logic [LINES-1:0] oh,
  input  logic             start,
  input  logic             loop_cond,
  output logic             cnt_en,
  output logic             par_ld,
  output logic [W-1:0]     ld_val,
  output logic             illegal
);

  // Any decoded value beyond the five legal codes falls back to idle.
  assign illegal = |oh[LINES-1:ST_COUNT];

  always_comb begin
    cnt_en = (oh[ST_IDLE] & start) | oh[ST_SETUP] | oh[ST_PREP] | oh[ST_UPD];
    par_ld = (oh[ST_IDLE] & ~start) | oh[ST_TEST] | illegal;
    ld_val = (oh[ST_TEST] & loop_cond) ? W'(ST_PREP) : W'(ST_IDLE);
  end

endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
  import seq_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [ST_COUNT-1:0] st,
  output strobe_t             stb,
  output logic                done_q
);

  assign stb = strobes_of(st);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b1;
    end else begin
      done_q <= flag_next(done_q, stb.done_set, stb.done_clr);
    end
  end

endmodule

// File: rtl/ctr_seq_ctrl.sv
module ctr_seq_ctrl
  import seq_ctrl_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic loop_cond,
  output logic src_load,
  output logic acc_load,
  output logic tol_load,
  output logic tmp_load,
  output logic est_load,
  output logic tmp_sel,
  output logic acc_sel,
  output logic done
);

  localparam int LINES = 1 << CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;
  logic [LINES-1:0] state_oh;
  logic             cnt_en;
  logic             par_ld;
  logic             illegal;
  strobe_t          stb;

  seq_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .par_ld (par_ld),
    .ld_val (ld_val),
    .q      (cnt_q)
  );

  seq_decoder #(.W(CNT_W), .LINES(LINES)) u_dec (
    .q  (cnt_q),
    .oh (state_oh)
  );

  seq_branch #(.W(CNT_W), .LINES(LINES)) u_br (
    .oh        (state_oh),
    .start     (start),
    .loop_cond (loop_cond),
    .cnt_en    (cnt_en),
    .par_ld    (par_ld),
    .ld_val    (ld_val),
    .illegal   (illegal)
  );

  seq_strobes u_stb (
    .clk    (clk),
    .rst    (rst),
    .st     (state_oh[ST_COUNT-1:0]),
    .stb    (stb),
    .done_q (done)
  );

  assign src_load = stb.src_load;
  assign acc_load = stb.acc_load;
  assign tol_load = stb.tol_load;
  assign tmp_load = stb.tmp_load;
  assign est_load = stb.est_load;
  assign tmp_sel  = stb.tmp_sel;
  assign acc_sel  = stb.acc_sel;

endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             loop_cond,
  input logic             src_load,
  input logic             acc_load,
  input logic             tol_load,
  input logic             tmp_load,
  input logic             est_load,
  input logic             tmp_sel,
  input logic             acc_sel,
  input logic             done,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_en,
  input logic             par_ld,
  input logic             idle_line,
  input logic             illegal
);

  logic any_stb;
  assign any_stb = src_load | acc_load | tol_load | tmp_load | est_load | tmp_sel | acc_sel;

  AST_RESET_TO_IDLE: assert property (@(posedge clk) rst |=> (cnt_q == '0 && done && !any_stb)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (idle_line && !start) |=> (idle_line && done)); // R2
  AST_START_TO_SETUP: assert property (@(posedge clk) disable iff (rst) (idle_line && start) |=> (src_load && tol_load && !tmp_load)); // R3
  AST_SETUP_TO_PREP: assert property (@(posedge clk) disable iff (rst) src_load |=> (tmp_load && tmp_sel && !acc_load)); // R4
  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (rst) (acc_sel && loop_cond) |=> (tmp_load && tmp_sel)); // R5
  AST_EXIT_TO_IDLE: assert property (@(posedge clk) disable iff (rst) (acc_sel && !loop_cond) |=> (idle_line && !any_stb)); // R6
  AST_CE_LD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(cnt_en && par_ld)); // R6
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (rst) src_load |=> !done); // R7
  AST_DONE_HELD_MID: assert property (@(posedge clk) disable iff (rst) (tmp_load || est_load || acc_sel) |=> $stable(done)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) est_load |=> (acc_load && acc_sel)); // R8
  AST_COND_IGNORED: assert property (@(posedge clk) disable iff (rst) tmp_load |=> (est_load && !tmp_load)); // R9
  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (rst) illegal |=> (cnt_q == '0)); // R2

endmodule

bind ctr_seq_ctrl seq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .loop_cond (loop_cond),
  .src_load  (src_load),
  .acc_load  (acc_load),
  .tol_load  (tol_load),
  .tmp_load  (tmp_load),
  .est_load  (est_load),
  .tmp_sel   (tmp_sel),
  .acc_sel   (acc_sel),
  .done      (done),
  .cnt_q     (cnt_q),
  .cnt_en    (cnt_en),
  .par_ld    (par_ld),
  .idle_line (state_oh[0]),
  .illegal   (illegal)
);

// File: tb/test_ctr_seq_ctrl.sv
`timescale 1ns/1ps
module test_ctr_seq_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic loop_cond = 1'b0;
  logic src_load, acc_load, tol_load, tmp_load, est_load, tmp_sel, acc_sel, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  // Reference model: state number 0..4 and done flag.
  int   m_st = 0;
  logic m_done = 1'b1;

  always #2.5 clk = ~clk;

  ctr_seq_ctrl i_ctr_seq_ctrl (
    .clk(clk), .rst(rst), .start(start), .loop_cond(loop_cond),
    .src_load(src_load), .acc_load(acc_load), .tol_load(tol_load),
    .tmp_load(tmp_load), .est_load(est_load), .tmp_sel(tmp_sel),
    .acc_sel(acc_sel), .done(done)
  );

  // Vector order: {done, src, acc, tol, tmp_load, est, tmp_sel, acc_sel}
  function automatic logic [6:0] model_stb(input int st);
    case (st)
      1:       return 7'b111_0000;
      2:       return 7'b000_1010;
      3:       return 7'b000_0100;
      4:       return 7'b010_0001;
      default: return 7'b000_0000;
    endcase
  endfunction

  task automatic drive(input logic r, input logic s, input logic c, input string tag);
    @(negedge clk);
    q_exp.push_back({m_done, model_stb(m_st)});
    q_tag.push_back(tag);
    rst = r; start = s; loop_cond = c;
    if (r) begin
      m_st = 0; m_done = 1'b1;
    end else begin
      if (m_st == 0) m_done = 1'b1;
      else if (m_st == 1) m_done = 1'b0;
      case (m_st)
        0: m_st = s ? 1 : 0;
        1: m_st = 2;
        2: m_st = 3;
        3: m_st = 4;
        default: m_st = c ? 2 : 0;
      endcase
    end
  endtask

  // Monitor: compare after the driver has pushed for this falling edge.
  always @(negedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = {done, src_load, acc_load, tol_load, tmp_load, est_load, tmp_sel, acc_sel};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(0, 0, 0, "R1 reset state");
    drive(0, 0, 1, "R2 idle hold, R9 cond ignored");
    drive(0, 0, 0, "R2 idle hold");
    drive(0, 1, 1, "R2 idle before start");
    drive(0, 1, 0, "R3 setup, R8 start held");
    drive(0, 1, 1, "R4 prepare, R7 done cleared, R9");
    drive(0, 1, 0, "R4 update, R8");
    drive(0, 1, 1, "R5 test loop back");
    drive(0, 0, 0, "R5 prepare after loop");
    drive(0, 0, 1, "R4 update, R9");
    drive(0, 0, 0, "R6 test exit");
    drive(0, 0, 1, "R6 idle after exit, R7 done still low");
    drive(0, 0, 0, "R7 done set again");
    // Back-to-back runs with start held high continuously
    drive(0, 1, 0, "R2 idle, start");
    for (int n = 0; n < 3; n++) begin
      drive(0, 1, 1, "R3 setup, R8");
      drive(0, 1, 0, "R4 prepare, R7");
      drive(0, 1, 0, "R4 update, R9");
      drive(0, 1, (n == 2) ? 1'b1 : 1'b0, "R5 test, R6");
      if (n == 2) begin
        drive(0, 1, 0, "R5 loop prepare");
        drive(0, 1, 0, "R4 update");
        drive(0, 1, 1, "R5 test loop again");
        drive(0, 0, 0, "R5 prepare");
        drive(0, 0, 1, "R4 update");
        drive(0, 0, 0, "R6 test exit");
      end
      drive(0, (n == 2) ? 1'b0 : 1'b1, 0, "R6 idle, R7 done low");
    end
    drive(0, 0, 0, "R7 done high");
    // Reset in the middle of a run
    drive(0, 1, 0, "R2 idle, start");
    drive(0, 0, 0, "R3 setup");
    drive(0, 0, 0, "R4 prepare");
    drive(1, 1, 1, "R4 update, reset requested");
    drive(0, 0, 0, "R1 reset mid-run");
    drive(0, 0, 0, "R1 R2 idle after reset");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule